// File: doc/BRIEF.md
# Rational resize phase sequencer

This block prepares the per-slot phase information for one axis of an image resizer. It takes an output length and an input length and forms the ratio output:input. It reduces that ratio to lowest terms, and it checks that the reduced numerator fits the coefficient table. If it does not fit, it nudges the output length upward until a usable ratio appears or the output length passes a supplied ceiling. The reduced numerator and denominator are reported along with an error flag and a resize-enable flag.

When resizing is needed, the block streams a table-start marker and then one (weight, step) entry per table slot over a valid/ready handshake. A weight of 512 means all of the current source pixel and 0 means all of the next one. The step is how many source pixels to advance after the slot. A downstream filter-tap generator and table writer consume the stream. The reduced ratio chooses how entries are formed: shrinking, whole-number enlarging or fractional enlarging. A 1:1 ratio turns resizing off and emits nothing.

Top module: `rsz_phase_seq`

## Requirements
- R1: After a successful start, `num_o`/`den_o` hold output length and input length divided by their greatest common divisor g, where the output length is the first one that satisfies R2.
- R2: A candidate output length n is rejected when n > 31·g (31 = table slots, parameter TBL_MAX). The candidate then grows by one and is retried. Once the candidate exceeds `max_len_i`, `err_o` is set, `rsz_en_o` stays 0 and no stream item is sent.
- R3: An output or input length of zero sets `err_o`, with no stream.
- R4: Every stream begins with one marker item: `ent_mark_o`=1, `ent_wt_o` all ones and `ent_step_o` all ones. It is followed by exactly `num_o` entries with `ent_mark_o`=0.
- R5: Shrinking (den > num): the accumulator a starts at den. Per entry, a = num + (a−num) mod 2num, then weight = 512 − 512·(a−num)/(2num) with integer division, then a += 2den, then step = (a−num)/(2num).
- R6: Whole-number enlarging (den = 1): every weight is 512, and the step is 1 on the last entry and 0 on all the others.
- R7: Fractional enlarging (other ratios): the accumulator a starts at 0. Per entry, weight = 512 − 512·a/num, then a += den, and if a ≥ num the step is 1 and a −= num, otherwise the step is 0.
- R8: A reduced ratio of 1:1 leaves `rsz_en_o`=0 and `err_o`=0 and sends no stream item.
- R9: When resizing, `tbl_idx_o` equals `num_o` − 1.
- R10: While `ent_valid_o` is high and `ent_ready_i` is low, the item on the stream outputs stays unchanged.
- R11: `busy_o` rises the cycle after an accepted start and stays high until the last item is accepted. `done_o` pulses for one cycle as busy falls. A start during busy is ignored.
- R12: After reset, the block is idle with `busy_o`, `done_o`, `err_o`, `rsz_en_o` and `ent_valid_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new ratio, taken when idle |
| out_len_i | input | LW | Requested output length |
| in_len_i | input | LW | Input length |
| max_len_i | input | LW | Ceiling for the output-length search |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 1 | No usable ratio |
| rsz_en_o | output | 1 | Resizing active on this axis |
| num_o | output | LW | Reduced numerator |
| den_o | output | LW | Reduced denominator |
| tbl_idx_o | output | IW | Last table slot index |
| ent_valid_o | output | 1 | Stream item valid |
| ent_ready_i | input | 1 | Consumer accepts the item |
| ent_mark_o | output | 1 | Item is the table-start marker |
| ent_wt_o | output | WW | Slot weight, 512 = current pixel only |
| ent_step_o | output | LW | Source pixels to advance |

## Verification
The hardest state to reach is the retry search. It needs an input pair whose raw gcd is too small for the table. That pair must still become reducible within the ceiling, or must run out of room against a tight ceiling. Table vectors 37:64 are chosen for this: with a ceiling of 64 the search moves on to 38 and lands on 19:32. With a ceiling of 37 the same pair exhausts the search and must end in an error. A stalling ready pattern and a mid-job start pulse carrying different lengths are layered on some vectors. These show that held items and the running job are both undisturbed.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  typedef enum logic [1:0] {
    MODE_SHRINK = 2'd0,
    MODE_WHOLE  = 2'd1,
    MODE_FRAC   = 2'd2
  } rsz_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_GCD, S_TEST, S_DN, S_DD, S_CLASS,
    S_MARK, S_DSI, S_PREP, S_FW, S_DW, S_DO, S_OUT
  } rsz_state_e;

endpackage

// File: rtl/rsz_gcd.sv
module rsz_gcd #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         done,
  output logic [W-1:0] g
);
  logic [W-1:0] a_r, b_r;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_r  <= '0;
      b_r  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        a_r <= a_in;
        b_r <= b_in;
        run <= 1'b1;
      end else if (run) begin
        if (a_r == b_r) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else if (a_r > b_r) begin
          a_r <= a_r - b_r;
        end else begin
          b_r <= b_r - a_r;
        end
      end
    end
  end

  assign g = a_r;
endmodule

// File: rtl/rsz_div.sv
module rsz_div #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dvs_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic [W:0]    diff;

  assign trial = {rem, quo[W-1]};
  assign diff  = trial - {1'b0, dvs_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      dvs_r <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo   <= dvd;
        rem   <= '0;
        dvs_r <= dvs;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        if (diff[W]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end else begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
  import rsz_pkg::*;
#(
  parameter int LW      = 12,
  parameter int WSHIFT  = 9,
  parameter int TBL_MAX = 31,
  localparam int WW     = WSHIFT + 1,
  localparam int IW     = $clog2(TBL_MAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [LW-1:0] out_len_i,
  input  logic [LW-1:0] in_len_i,
  input  logic [LW-1:0] max_len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          rsz_en_o,
  output logic [LW-1:0] num_o,
  output logic [LW-1:0] den_o,
  output logic [IW-1:0] tbl_idx_o,
  output logic          ent_valid_o,
  input  logic          ent_ready_i,
  output logic          ent_mark_o,
  output logic [WW-1:0] ent_wt_o,
  output logic [LW-1:0] ent_step_o
);
  localparam int DW = LW + WSHIFT + 2;
  localparam int PW = LW + $clog2(TBL_MAX + 1);
  localparam logic [WW-1:0] W_ONE = WW'(1) << WSHIFT;

  rsz_state_e st;
  rsz_mode_e  mode_r;

  logic [LW-1:0] num_r, den_r, max_r, g_r, cnt_r;
  logic [LW:0]   acc_r;
  logic [LW+1:0] r_r;

  logic          gcd_go, gcd_done;
  logic [LW-1:0] gcd_g;
  logic          div_go, div_done;
  logic [DW-1:0] div_a, div_b, div_q, div_rem;

  logic [PW-1:0] lim;
  logic [LW+1:0] fsum;
  logic [DW-1:0] two_num;
  logic          last_slot;

  assign lim       = PW'(TBL_MAX) * PW'(g_r);
  assign fsum      = (LW+2)'(acc_r) + (LW+2)'(den_r);
  assign two_num   = DW'(num_r) << 1;
  assign last_slot = (cnt_r == num_r - 1'b1);

  rsz_gcd #(.W(LW)) u_gcd (
    .clk(clk), .rst(rst), .go(gcd_go), .a_in(num_r), .b_in(den_r),
    .done(gcd_done), .g(gcd_g)
  );

  rsz_div #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dvd(div_a), .dvs(div_b),
    .done(div_done), .quo(div_q), .rem(div_rem)
  );

  assign busy_o = (st != S_IDLE);
  assign num_o  = num_r;
  assign den_o  = den_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      mode_r      <= MODE_FRAC;
      num_r       <= '0;
      den_r       <= '0;
      max_r       <= '0;
      g_r         <= '0;
      cnt_r       <= '0;
      acc_r       <= '0;
      r_r         <= '0;
      gcd_go      <= 1'b0;
      div_go      <= 1'b0;
      div_a       <= '0;
      div_b       <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      rsz_en_o    <= 1'b0;
      tbl_idx_o   <= '0;
      ent_valid_o <= 1'b0;
      ent_mark_o  <= 1'b0;
      ent_wt_o    <= '0;
      ent_step_o  <= '0;
    end else begin
      done_o <= 1'b0;
      gcd_go <= 1'b0;
      div_go <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            num_r     <= out_len_i;
            den_r     <= in_len_i;
            max_r     <= max_len_i;
            err_o     <= 1'b0;
            rsz_en_o  <= 1'b0;
            tbl_idx_o <= '0;
            st        <= S_CHK;
          end
        end
        S_CHK: begin
          if (num_r == '0 || den_r == '0 || num_r > max_r) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            gcd_go <= 1'b1;
            st     <= S_GCD;
          end
        end
        S_GCD: begin
          if (gcd_done) begin
            g_r <= gcd_g;
            st  <= S_TEST;
          end
        end
        S_TEST: begin
          if (PW'(num_r) > lim) begin
            num_r <= num_r + 1'b1;
            st    <= S_CHK;
          end else begin
            div_a  <= DW'(num_r);
            div_b  <= DW'(g_r);
            div_go <= 1'b1;
            st     <= S_DN;
          end
        end
        S_DN: begin
          if (div_done) begin
            num_r  <= div_q[LW-1:0];
            div_a  <= DW'(den_r);
            div_b  <= DW'(g_r);
            div_go <= 1'b1;
            st     <= S_DD;
          end
        end
        S_DD: begin
          if (div_done) begin
            den_r <= div_q[LW-1:0];
            st    <= S_CLASS;
          end
        end
        S_CLASS: begin
          if (num_r == LW'(1) && den_r == LW'(1)) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            rsz_en_o    <= 1'b1;
            tbl_idx_o   <= IW'(num_r - 1'b1);
            if (den_r > num_r)        mode_r <= MODE_SHRINK;
            else if (den_r == LW'(1)) mode_r <= MODE_WHOLE;
            else                      mode_r <= MODE_FRAC;
            acc_r       <= '0;
            cnt_r       <= '0;
            ent_valid_o <= 1'b1;
            ent_mark_o  <= 1'b1;
            ent_wt_o    <= '1;
            ent_step_o  <= '1;
            st          <= S_MARK;
          end
        end
        S_MARK: begin
          if (ent_ready_i) begin
            ent_valid_o <= 1'b0;
            ent_mark_o  <= 1'b0;
            if (mode_r == MODE_SHRINK) begin
              div_a  <= DW'(den_r - num_r);
              div_b  <= two_num;
              div_go <= 1'b1;
              st     <= S_DSI;
            end else begin
              st <= S_PREP;
            end
          end
        end
        S_DSI: begin
          if (div_done) begin
            r_r <= div_rem[LW+1:0];
            st  <= S_PREP;
          end
        end
        S_PREP: begin
          case (mode_r)
            MODE_WHOLE: begin
              ent_wt_o    <= W_ONE;
              ent_step_o  <= LW'(last_slot);
              ent_valid_o <= 1'b1;
              st          <= S_OUT;
            end
            MODE_SHRINK: begin
              div_a  <= DW'(r_r) << WSHIFT;
              div_b  <= two_num;
              div_go <= 1'b1;
              st     <= S_DW;
            end
            default: begin
              div_a  <= DW'(acc_r) << WSHIFT;
              div_b  <= DW'(num_r);
              div_go <= 1'b1;
              st     <= S_FW;
            end
          endcase
        end
        S_FW: begin
          if (div_done) begin
            ent_wt_o <= W_ONE - div_q[WW-1:0];
            if (fsum >= (LW+2)'(num_r)) begin
              ent_step_o <= LW'(1);
              acc_r      <= (LW+1)'(fsum - (LW+2)'(num_r));
            end else begin
              ent_step_o <= '0;
              acc_r      <= (LW+1)'(fsum);
            end
            ent_valid_o <= 1'b1;
            st          <= S_OUT;
          end
        end
        S_DW: begin
          if (div_done) begin
            ent_wt_o <= W_ONE - div_q[WW-1:0];
            div_a    <= DW'(r_r) + (DW'(den_r) << 1);
            div_b    <= two_num;
            div_go   <= 1'b1;
            st       <= S_DO;
          end
        end
        S_DO: begin
          if (div_done) begin
            ent_step_o  <= div_q[LW-1:0];
            r_r         <= div_rem[LW+1:0];
            ent_valid_o <= 1'b1;
            st          <= S_OUT;
          end
        end
        S_OUT: begin
          if (ent_ready_i) begin
            ent_valid_o <= 1'b0;
            cnt_r       <= cnt_r + 1'b1;
            if (last_slot) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_PREP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsz_phase_seq_chk.sv
module rsz_phase_seq_chk #(
  parameter int LW = 12,
  parameter int WW = 10,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          rsz_en_o,
  input logic [LW-1:0] num_o,
  input logic [IW-1:0] tbl_idx_o,
  input logic          ent_valid_o,
  input logic          ent_ready_i,
  input logic          ent_mark_o,
  input logic [WW-1:0] ent_wt_o,
  input logic [LW-1:0] ent_step_o
);
  localparam logic [WW-1:0] W_ONE = WW'(1) << (WW - 1);

  a_r10_hold_item: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_o && !ent_ready_i) |=> (ent_valid_o && $stable(ent_wt_o)
      && $stable(ent_step_o) && $stable(ent_mark_o)));

  a_r11_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
    ent_valid_o |-> busy_o);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r4_marker_fields: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_o && ent_mark_o) |-> (ent_wt_o == '1 && ent_step_o == '1));

  a_r5_weight_range: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_o && !ent_mark_o) |-> (ent_wt_o != '0 && ent_wt_o <= W_ONE));

  a_r2_err_silent: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!ent_valid_o && !rsz_en_o));

  a_r9_last_index: assert property (@(posedge clk) disable iff (rst)
    (done_o && rsz_en_o) |-> (tbl_idx_o == IW'(num_o - 1'b1)));
endmodule

bind rsz_phase_seq rsz_phase_seq_chk #(.LW(LW), .WW(WW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .rsz_en_o(rsz_en_o), .num_o(num_o), .tbl_idx_o(tbl_idx_o),
  .ent_valid_o(ent_valid_o), .ent_ready_i(ent_ready_i),
  .ent_mark_o(ent_mark_o), .ent_wt_o(ent_wt_o), .ent_step_o(ent_step_o)
);

// File: tb/sim_rsz_phase_seq.sv
module sim_rsz_phase_seq;
  localparam int LW = 12;
  localparam int WW = 10;
  localparam int IW = 5;
  localparam int NV = 10;
  // columns: out_len, in_len, max_len, stall pattern, inject start mid-job
  localparam int VEC [0:NV-1][0:4] = '{
    '{320, 240, 400, 0, 0},
    '{240, 320, 400, 1, 1},
    '{640, 320, 700, 0, 0},
    '{100, 100, 200, 0, 0},
    '{37,  64,  64,  1, 0},
    '{37,  64,  37,  0, 0},
    '{0,   64,  64,  0, 0},
    '{31,  7,   40,  1, 0},
    '{5,   200, 300, 0, 0},
    '{3,   1,   10,  1, 1}
  };

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, ent_ready_i = 1'b0;
  logic [LW-1:0] out_len_i = '0, in_len_i = '0, max_len_i = '0;
  logic busy_o, done_o, err_o, rsz_en_o, ent_valid_o, ent_mark_o;
  logic [LW-1:0] num_o, den_o, ent_step_o;
  logic [IW-1:0] tbl_idx_o;
  logic [WW-1:0] ent_wt_o;

  int n_chk = 0, n_bad = 0;
  int e_err, e_en, e_num, e_den;
  int e_wt [0:31];
  int e_st [0:31];
  int g_cnt;
  int g_wt [0:40];
  int g_st [0:40];
  int g_mk [0:40];

  always #2.5 clk = ~clk;

  rsz_phase_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .out_len_i(out_len_i),
    .in_len_i(in_len_i), .max_len_i(max_len_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .rsz_en_o(rsz_en_o), .num_o(num_o),
    .den_o(den_o), .tbl_idx_o(tbl_idx_o), .ent_valid_o(ent_valid_o),
    .ent_ready_i(ent_ready_i), .ent_mark_o(ent_mark_o),
    .ent_wt_o(ent_wt_o), .ent_step_o(ent_step_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gcd_f(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  // expected results from the requirement formulas
  task automatic model(input int o, input int i, input int mx);
    int n = o, g = 1, acc;
    bit found = 0;
    e_err = 0; e_en = 0; e_num = 0; e_den = 0;
    if (o == 0 || i == 0) e_err = 1;               // R3
    else begin
      while (!found && n <= mx) begin               // R2
        g = gcd_f(n, i);
        if (n <= 31 * g) found = 1; else n++;
      end
      if (!found) e_err = 1;
    end
    if (e_err) return;
    e_num = n / g; e_den = i / g;                   // R1
    e_en = !(e_num == 1 && e_den == 1);             // R8
    if (e_den > e_num) begin                        // R5
      acc = e_den;
      for (int k = 0; k < e_num; k++) begin
        acc = e_num + (acc - e_num) % (2 * e_num);
        e_wt[k] = 512 - 512 * (acc - e_num) / (2 * e_num);
        acc += 2 * e_den;
        e_st[k] = (acc - e_num) / (2 * e_num);
      end
    end else if (e_den == 1) begin                  // R6
      for (int k = 0; k < e_num; k++) begin
        e_wt[k] = 512; e_st[k] = (k == e_num - 1) ? 1 : 0;
      end
    end else begin                                  // R7
      acc = 0;
      for (int k = 0; k < e_num; k++) begin
        e_wt[k] = 512 - 512 * acc / e_num;
        acc += e_den;
        if (acc >= e_num) begin e_st[k] = 1; acc -= e_num; end
        else e_st[k] = 0;
      end
    end
  endtask

  task automatic run_job(input int o, input int i, input int mx,
                         input int stall, input int inject);
    int cyc = 0;
    g_cnt = 0;
    @(negedge clk);
    out_len_i = LW'(o); in_len_i = LW'(i); max_len_i = LW'(mx);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R11 busy after start", int'(busy_o), 1);
    while (!done_o && cyc < 20000) begin
      if (inject != 0 && cyc == 4) begin
        // R11: start with other lengths while busy must be ignored
        start_i = 1'b1; out_len_i = 12'd9; in_len_i = 12'd5; max_len_i = 12'd9;
      end else start_i = 1'b0;
      if (ent_valid_o) begin
        ent_ready_i = (stall != 0) ? (cyc % 3 != 0) : 1'b1;
        if (ent_ready_i && g_cnt <= 40) begin
          g_wt[g_cnt] = int'(ent_wt_o);
          g_st[g_cnt] = int'(ent_step_o);
          g_mk[g_cnt] = int'(ent_mark_o);
          g_cnt++;
        end
      end else ent_ready_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; ent_ready_i = 1'b0;
    check(done_o == 1'b1, "R11 done reached", int'(done_o), 1);
    check(busy_o == 1'b0, "R11 idle at done", int'(busy_o), 0);
    @(negedge clk);
    check(done_o == 1'b0, "R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic compare(input int v);
    check(int'(err_o) == e_err, $sformatf("R2 R3 err v%0d", v), int'(err_o), e_err);
    check(int'(rsz_en_o) == e_en, $sformatf("R8 enable v%0d", v), int'(rsz_en_o), e_en);
    if (e_err) begin
      check(g_cnt == 0, $sformatf("R2 no stream v%0d", v), g_cnt, 0);
      return;
    end
    check(int'(num_o) == e_num, $sformatf("R1 num v%0d", v), int'(num_o), e_num);
    check(int'(den_o) == e_den, $sformatf("R1 den v%0d", v), int'(den_o), e_den);
    if (!e_en) begin
      check(g_cnt == 0, $sformatf("R8 no stream v%0d", v), g_cnt, 0);
      return;
    end
    check(int'(tbl_idx_o) == e_num - 1, $sformatf("R9 index v%0d", v), int'(tbl_idx_o), e_num - 1);
    check(g_cnt == e_num + 1, $sformatf("R4 item count v%0d", v), g_cnt, e_num + 1);
    check(g_mk[0] == 1 && g_wt[0] == 1023 && g_st[0] == 4095,
          $sformatf("R4 marker v%0d", v), g_wt[0], 1023);
    for (int k = 0; k < e_num && k + 1 < g_cnt; k++) begin
      check(g_mk[k+1] == 0, $sformatf("R4 no marker v%0d e%0d", v, k), g_mk[k+1], 0);
      check(g_wt[k+1] == e_wt[k], $sformatf("R5 R6 R7 R10 weight v%0d e%0d", v, k), g_wt[k+1], e_wt[k]);
      check(g_st[k+1] == e_st[k], $sformatf("R5 R6 R7 R10 step v%0d e%0d", v, k), g_st[k+1], e_st[k]);
    end
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(busy_o == 0, "R12 busy", int'(busy_o), 0);
    check(done_o == 0, "R12 done", int'(done_o), 0);
    check(err_o == 0, "R12 err", int'(err_o), 0);
    check(rsz_en_o == 0, "R12 enable", int'(rsz_en_o), 0);
    check(ent_valid_o == 0, "R12 valid", int'(ent_valid_o), 0);

    for (int v = 0; v < NV; v++) begin
      model(VEC[v][0], VEC[v][1], VEC[v][2]);
      run_job(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      compare(v);
    end

    // directed: zero input length with nonzero output length (R3)
    model(8, 0, 20);
    run_job(8, 0, 20, 0, 0);
    compare(100);

    // directed: reset in the middle of a stream returns to idle (R12)
    @(negedge clk);
    out_len_i = 12'd31; in_len_i = 12'd7; max_len_i = 12'd40; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && ent_valid_o == 0, "R12 mid-job reset", int'(busy_o), 0);
    check(rsz_en_o == 0, "R12 enable after reset", int'(rsz_en_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule